// File: doc/BRIEF.md
# Pipeline Hazard and Stall Controller

This block decides, every clock, which stages of a five-stage in-order pipeline may advance. The stages are prefetch, decode, operand read, a combined ALU/memory issue stage, and writeback. The block receives the valid bits and decoded attributes of the instructions in operand read and in the issue stage. It also receives the state of the memory unit, prefetch validity and the writeback redirect request. It returns per-stage hold, clear and bubble controls.

The controller has no datapath of its own. A hold freezes a stage and every stage behind it. Stages ahead of the frozen one keep draining, and the first of them to advance loads a bubble. A redirect from writeback (a taken branch, a jump, an interrupt entry or an interrupt return) discards everything younger than writeback in the same cycle. It then holds prefetch for one clock, so that prefetch sees a valid program counter before it produces output. With the five stages refilling, this gives a six-clock redirect penalty. An operation already inside the memory unit is never discarded.

Top module: `hzd_stall_ctrl`

## Requirements
- R1: When `wb_flush_i` is high, `clear_o` is all ones, and `stall_o` and `bubble_o` are all zero in that same cycle, whatever hazard is present.
- R2: In the cycle after a flush, and from reset until the first clock edge after reset is released, the prefetch stage is held (`stall_o[0]`=1). Unless the flush repeats, this hold lasts one cycle only.
- R3: If operand read holds a valid instruction that adds an immediate to source register `op_src_reg_i`, and a valid issue-stage instruction writes that same register, operand read and all earlier stages are held (`stall_o[2:0]`=3'b111). Different registers give no hold.
- R4: A valid issue-stage instruction that may write PC or CC holds a valid operand-read instruction for one cycle. It does so whether or not the branch is later taken.
- R5: A valid operand-read instruction that reads CC is held while a valid issue-stage instruction sets flags. Without the CC read there is no hold.
- R6: While the memory unit is busy with a load, all four stages (`stall_o`=4'b1111) are held, and writeback receives a bubble.
- R7: While the memory unit is busy with a store, a valid memory instruction in operand read is held (`stall_o`=4'b0111). A non-memory instruction is not held.
- R8: When prefetch has no valid instruction, `stall_o` is 4'b1111.
- R9: Bit k of `stall_o` (0=prefetch, 1=decode, 2=operand read, 3=issue) holds the deepest stage with a hold cause, and every earlier stage. Bit k of `bubble_o` marks that stage k+1 (decode, operand read, issue, writeback) loads a bubble. Exactly one bubble bit is set when any stage is held, and none otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pf_valid_i | input | 1 | Prefetch has a valid instruction |
| op_valid_i | input | 1 | Operand-read stage valid |
| op_src_reg_i | input | REG_W | Register that gets the immediate added |
| op_uses_imm_i | input | 1 | Operand-read instruction adds an immediate to a register |
| op_reads_cc_i | input | 1 | Operand-read instruction reads CC |
| op_mem_i | input | 1 | Operand-read instruction is a load or a store |
| ex_valid_i | input | 1 | Issue stage valid |
| ex_dst_reg_i | input | REG_W | Issue-stage destination register |
| ex_writes_reg_i | input | 1 | Issue-stage instruction writes a register |
| ex_wr_pc_cc_i | input | 1 | Issue-stage instruction may write PC or CC |
| ex_sets_flags_i | input | 1 | Issue-stage instruction sets flags |
| mem_busy_i | input | 1 | Memory unit busy |
| mem_load_i | input | 1 | Busy operation is a load (else a store) |
| wb_flush_i | input | 1 | Writeback redirect |
| stall_o | output | 4 | Per-stage hold |
| clear_o | output | 4 | Per-stage invalidate |
| bubble_o | output | 4 | Bubble into the stage after stage k |

## Verification
Assertions check the following on every cycle: that a flush overrides all holds, that a load or an empty prefetch freezes the whole front, that register, flag and store conflicts hold operand read, that prefetch waits after a redirect, and that at most one bubble bit is set. Other things only the bench scenarios can show. These are the absence of holds when registers differ or the CC read is missing, that an ALU instruction passes a busy store, that the post-flush hold ends after one cycle, and that combined causes resolve to the deepest stage.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int NSTG  = 4;
  localparam int ST_PF = 0;
  localparam int ST_DC = 1;
  localparam int ST_OP = 2;
  localparam int ST_EX = 3;
endpackage

// File: rtl/hzd_operand_check.sv
module hzd_operand_check #(
  parameter int REG_W = 4
) (
  input  logic             op_valid_i,
  input  logic [REG_W-1:0] op_src_reg_i,
  input  logic             op_uses_imm_i,
  input  logic             op_reads_cc_i,
  input  logic             op_mem_i,
  input  logic             ex_valid_i,
  input  logic [REG_W-1:0] ex_dst_reg_i,
  input  logic             ex_writes_reg_i,
  input  logic             ex_wr_pc_cc_i,
  input  logic             ex_sets_flags_i,
  input  logic             store_busy_i,
  output logic             op_hold_o
);
  logic raw_imm, pc_cc_wr, cc_read, mem_order;

  always_comb begin
    raw_imm   = op_uses_imm_i && ex_writes_reg_i && (ex_dst_reg_i == op_src_reg_i);
    pc_cc_wr  = ex_wr_pc_cc_i;
    cc_read   = op_reads_cc_i && ex_sets_flags_i;
    mem_order = op_mem_i && store_busy_i;
    op_hold_o = op_valid_i && (mem_order || (ex_valid_i && (raw_imm || pc_cc_wr || cc_read)));
  end
endmodule

// File: rtl/hzd_refill.sv
module hzd_refill (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  output logic pf_hold_o
);
  logic refill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) refill_q <= 1'b1;
    else         refill_q <= flush_i;
  end

  assign pf_hold_o = refill_q;

  p_refill_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i) |=> !pf_hold_o);
endmodule

// File: rtl/hzd_stall_chain.sv
module hzd_stall_chain
  import hzd_pkg::*;
(
  input  logic [NSTG-1:0] cause_i,
  input  logic            flush_i,
  output logic [NSTG-1:0] stall_o,
  output logic [NSTG-1:0] clear_o,
  output logic [NSTG-1:0] bubble_o
);
  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    if (k == NSTG-1) begin : g_last
      assign stall_o[k]  = cause_i[k] && !flush_i;
      assign bubble_o[k] = stall_o[k];
    end else begin : g_mid
      assign stall_o[k]  = (cause_i[k] || stall_o[k+1]) && !flush_i;
      assign bubble_o[k] = stall_o[k] && !stall_o[k+1];
    end
    assign clear_o[k] = flush_i;
  end
endmodule

// File: rtl/hzd_stall_ctrl.sv
module hzd_stall_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pf_valid_i,
  input  logic             op_valid_i,
  input  logic [REG_W-1:0] op_src_reg_i,
  input  logic             op_uses_imm_i,
  input  logic             op_reads_cc_i,
  input  logic             op_mem_i,
  input  logic             ex_valid_i,
  input  logic [REG_W-1:0] ex_dst_reg_i,
  input  logic             ex_writes_reg_i,
  input  logic             ex_wr_pc_cc_i,
  input  logic             ex_sets_flags_i,
  input  logic             mem_busy_i,
  input  logic             mem_load_i,
  input  logic             wb_flush_i,
  output logic [3:0]       stall_o,
  output logic [3:0]       clear_o,
  output logic [3:0]       bubble_o
);
  logic            op_hold, pf_hold, ex_hold, load_busy, store_busy;
  logic [NSTG-1:0] cause;

  assign load_busy  = mem_busy_i && mem_load_i;
  assign store_busy = mem_busy_i && !mem_load_i;
  assign ex_hold    = load_busy || !pf_valid_i;

  hzd_operand_check #(.REG_W(REG_W)) u_opchk (
    .op_valid_i     (op_valid_i),
    .op_src_reg_i   (op_src_reg_i),
    .op_uses_imm_i  (op_uses_imm_i),
    .op_reads_cc_i  (op_reads_cc_i),
    .op_mem_i       (op_mem_i),
    .ex_valid_i     (ex_valid_i),
    .ex_dst_reg_i   (ex_dst_reg_i),
    .ex_writes_reg_i(ex_writes_reg_i),
    .ex_wr_pc_cc_i  (ex_wr_pc_cc_i),
    .ex_sets_flags_i(ex_sets_flags_i),
    .store_busy_i   (store_busy),
    .op_hold_o      (op_hold)
  );

  hzd_refill u_refill (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (wb_flush_i),
    .pf_hold_o(pf_hold)
  );

  always_comb begin
    cause        = '0;
    cause[ST_PF] = pf_hold;
    cause[ST_OP] = op_hold;
    cause[ST_EX] = ex_hold;
  end

  hzd_stall_chain u_chain (
    .cause_i (cause),
    .flush_i (wb_flush_i),
    .stall_o (stall_o),
    .clear_o (clear_o),
    .bubble_o(bubble_o)
  );

  p_flush_wins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_flush_i |-> (clear_o == 4'hF) && (stall_o == 4'h0) && (bubble_o == 4'h0));
  p_post_flush_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_flush_i |=> (stall_o[ST_PF] || wb_flush_i));
  p_imm_raw_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && ex_valid_i && op_uses_imm_i && ex_writes_reg_i &&
     op_src_reg_i == ex_dst_reg_i && !wb_flush_i) |-> (stall_o[2:0] == 3'b111));
  p_pc_cc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && ex_valid_i && ex_wr_pc_cc_i && !wb_flush_i) |-> stall_o[ST_OP]);
  p_cc_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && ex_valid_i && op_reads_cc_i && ex_sets_flags_i && !wb_flush_i) |-> stall_o[ST_OP]);
  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_busy_i && mem_load_i && !wb_flush_i) |-> (stall_o == 4'hF && bubble_o == 4'h8));
  p_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_busy_i && !mem_load_i && op_valid_i && op_mem_i && !wb_flush_i) |-> stall_o[ST_OP]);
  p_pf_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pf_valid_i && !wb_flush_i) |-> (stall_o == 4'hF));
  p_one_bubble_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bubble_o) && ((stall_o != 4'h0) == (bubble_o != 4'h0)));
endmodule

// File: tb/sim_hzd_stall_ctrl.sv
module sim_hzd_stall_ctrl;
  localparam int CLK_P = 10;
  localparam int REG_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pf_valid, op_valid, op_uses_imm, op_reads_cc, op_mem;
  logic ex_valid, ex_writes_reg, ex_wr_pc_cc, ex_sets_flags;
  logic mem_busy, mem_load, flush;
  logic [REG_W-1:0] op_src, ex_dst;
  logic [3:0] stall, clr, bubble;
  logic ref_refill;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  hzd_stall_ctrl #(.REG_W(REG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pf_valid_i(pf_valid), .op_valid_i(op_valid),
    .op_src_reg_i(op_src), .op_uses_imm_i(op_uses_imm), .op_reads_cc_i(op_reads_cc),
    .op_mem_i(op_mem), .ex_valid_i(ex_valid), .ex_dst_reg_i(ex_dst),
    .ex_writes_reg_i(ex_writes_reg), .ex_wr_pc_cc_i(ex_wr_pc_cc),
    .ex_sets_flags_i(ex_sets_flags), .mem_busy_i(mem_busy), .mem_load_i(mem_load),
    .wb_flush_i(flush), .stall_o(stall), .clear_o(clr), .bubble_o(bubble)
  );

  // prefetch waits one clock with a valid PC after reset or a redirect
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ref_refill <= 1'b1;
    else        ref_refill <= flush;

  // behavioural reference: deepest stage with any hold cause
  function automatic logic [11:0] model();
    int deepest = -1;
    logic [3:0] s = 0, b = 0;
    if (flush) return {4'h0, 4'hF, 4'h0};
    if (ref_refill) deepest = 0;
    if (op_valid && ((op_mem && mem_busy && !mem_load) ||
        (ex_valid && ((op_uses_imm && ex_writes_reg && op_src == ex_dst) ||
                      ex_wr_pc_cc || (op_reads_cc && ex_sets_flags)))))
      deepest = 2;
    if ((mem_busy && mem_load) || !pf_valid) deepest = 3;
    for (int k = 0; k < 4; k++) s[k] = (k <= deepest);
    if (deepest >= 0) b[deepest] = 1'b1;
    return {s, 4'h0, b};
  endfunction

  task automatic idle();
    pf_valid = 1; op_valid = 0; op_uses_imm = 0; op_reads_cc = 0; op_mem = 0;
    ex_valid = 0; ex_writes_reg = 0; ex_wr_pc_cc = 0; ex_sets_flags = 0;
    mem_busy = 0; mem_load = 0; flush = 0; op_src = 0; ex_dst = 0;
  endtask

  task automatic expect_out(string req, logic [3:0] es, logic [3:0] ec, logic [3:0] eb);
    checks++;
    if (stall !== es || clr !== ec || bubble !== eb) begin
      errors++;
      $display("FAIL %s: stall/clear/bubble actual %b/%b/%b expected %b/%b/%b",
               req, stall, clr, bubble, es, ec, eb);
    end
  endtask

  task automatic settle();
    #(CLK_P/4);
  endtask

  initial begin
    idle();
    @(negedge clk); settle();
    expect_out("R2 reset", 4'b0001, 4'b0000, 4'b0001);
    @(negedge clk); rst_n = 1;
    @(negedge clk); settle();
    expect_out("R9 idle", 4'b0000, 4'b0000, 4'b0000);

    @(negedge clk); op_valid = 1; ex_valid = 1; op_uses_imm = 1; ex_writes_reg = 1;
    op_src = 5; ex_dst = 5; settle();
    expect_out("R3 same reg", 4'b0111, 4'b0000, 4'b0100);
    @(negedge clk); ex_dst = 6; settle();
    expect_out("R3 other reg", 4'b0000, 4'b0000, 4'b0000);
    @(negedge clk); ex_dst = 5; ex_valid = 0; settle();
    expect_out("R3 ex invalid", 4'b0000, 4'b0000, 4'b0000);

    @(negedge clk); idle(); op_valid = 1; ex_valid = 1; ex_wr_pc_cc = 1; settle();
    expect_out("R4 pc/cc write", 4'b0111, 4'b0000, 4'b0100);

    @(negedge clk); idle(); op_valid = 1; ex_valid = 1; ex_sets_flags = 1; op_reads_cc = 1; settle();
    expect_out("R5 cc read", 4'b0111, 4'b0000, 4'b0100);
    @(negedge clk); op_reads_cc = 0; settle();
    expect_out("R5 no cc read", 4'b0000, 4'b0000, 4'b0000);

    @(negedge clk); idle(); op_valid = 1; mem_busy = 1; mem_load = 1; settle();
    expect_out("R6 load busy", 4'b1111, 4'b0000, 4'b1000);

    @(negedge clk); mem_load = 0; op_mem = 1; settle();
    expect_out("R7 store vs mem op", 4'b0111, 4'b0000, 4'b0100);
    @(negedge clk); op_mem = 0; settle();
    expect_out("R7 store vs alu op", 4'b0000, 4'b0000, 4'b0000);

    @(negedge clk); idle(); pf_valid = 0; settle();
    expect_out("R8 prefetch empty", 4'b1111, 4'b0000, 4'b1000);

    @(negedge clk); idle(); mem_busy = 1; mem_load = 1; flush = 1; settle();
    expect_out("R1 flush over load", 4'b0000, 4'b1111, 4'b0000);
    @(negedge clk); idle(); settle();
    expect_out("R2 post flush", 4'b0001, 4'b0000, 4'b0001);
    @(negedge clk); settle();
    expect_out("R2 single cycle", 4'b0000, 4'b0000, 4'b0000);

    @(negedge clk); flush = 1; settle();
    expect_out("R1 flush", 4'b0000, 4'b1111, 4'b0000);
    @(negedge clk); idle(); op_valid = 1; ex_valid = 1; ex_wr_pc_cc = 1; settle();
    expect_out("R9 refill plus op hold", 4'b0111, 4'b0000, 4'b0100);

    for (int i = 0; i < 4000; i++) begin
      logic [11:0] e;
      @(negedge clk);
      pf_valid = ($urandom_range(0, 7) != 0);
      op_valid = $urandom_range(0, 1); ex_valid = $urandom_range(0, 1);
      op_uses_imm = $urandom_range(0, 1); ex_writes_reg = $urandom_range(0, 1);
      op_src = REG_W'($urandom_range(0, 3)); ex_dst = REG_W'($urandom_range(0, 3));
      op_reads_cc = $urandom_range(0, 1); ex_sets_flags = ($urandom_range(0, 3) == 0);
      ex_wr_pc_cc = ($urandom_range(0, 5) == 0); op_mem = $urandom_range(0, 1);
      mem_busy = ($urandom_range(0, 3) == 0); mem_load = $urandom_range(0, 1);
      flush = ($urandom_range(0, 9) == 0);
      settle();
      e = model();
      expect_out("R9 random", e[11:8], e[7:4], e[3:0]);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule